// File: doc/BRIEF.md
# Board Control Register File

This block is a small memory-mapped register file for a development board's control logic. A host drives an address, a write data word and a write enable on a plain synchronous bus. The block returns read data one cycle after the address is presented. It holds an 8-bit LED bar value and an eight-character text display buffer. The display can be loaded one character at a time, or from a single 32-bit word. For a word load, the hardware converts the value into eight uppercase hexadecimal ASCII characters.

The block also has these functions:
- It raises a one-cycle system reset request when its soft-reset register is written.
- It holds an 8-bit general-purpose output.
- It drives a bit-banged I2C port that is wired to an on-board serial EEPROM. Two clock/data bits are driven toward the EEPROM, and the EEPROM's data line is read back through an input register.

Only the low 20 address bits take part in decoding. The 256-byte window at 0x900 to 0x9FF belongs to a neighbouring UART and is left alone. The bus has no back-pressure, so every cycle accepts one access. No access is ever stalled.

Top module: `board_ctrl_regs`

## Requirements
- R1: Decoding uses only address bits 19:0. An access whose upper twelve bits are non-zero behaves exactly like the same access with those bits cleared.
- R2: A write to the LED register (offset 0x00400) stores write-data bits 7:0 on `led_bar`, where bit 7 is the leftmost LED. A read returns the value in bits 7:0 and zeros above. No other access changes `led_bar`.
- R3: A write to the hex-word register (offset 0x00410) loads all eight display characters with the uppercase ASCII hex digits of the 32-bit data ('0'-'9' = 0x30-0x39, 'A'-'F' = 0x41-0x46). The most significant nibble goes to character 0. Character i appears on `disp_chars[8*i+7:8*i]`, and character 0 is the leftmost.
- R4: Character i (0..7) is written at offset 0x418 + 8*i and stores write-data bits 7:0. The other seven characters keep their values. A write to a non-multiple-of-8 offset inside that range, or to 0x458 and above, leaves the display unchanged.
- R5: Reset is asynchronous and active low. It sets every display character to a space (0x20) and sets the LED bar, general-purpose output, I2C lines, I2C output enables, I2C select, reset request and read data to zero.
- R6: A write of any value to the soft-reset register (offset 0x00500) drives `sys_reset_req` high for exactly the one cycle after the write edge. At all other times it is low.
- R7: The I2C output register (offset 0x00B08) drives write-data bit 1 to `i2c_scl_out` and bit 0 to `i2c_sda_out`. The output-enable register (0x00B04) keeps bits 1:0 and the select register (0x00B0C) keeps bit 0. All three read back at the same positions.
- R8: A read of the I2C input register (offset 0x00B00) returns in bit 0 the level of `eeprom_sda_in` at the addressing edge, and zeros above. A read of the switch register (offset 0x00100) always returns zero.
- R9: Writes to offsets 0x900 to 0x9FF have no effect on any output, and reads there return zero. A read of any unassigned offset returns zero.
- R10: Read data is registered: `bus_rdata` reflects the offset presented at the previous clock edge and the state before any write made at that same edge. A read without write enable changes no state.
- R11: A write to the general-purpose output register (offset 0x00A00) stores write-data bits 7:0 on `gp_out`, and the value reads back in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address; bits 19:0 decoded |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable for this cycle's access |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| led_bar | output | 8 | LED bar, bit 7 leftmost |
| disp_chars | output | 64 | Eight ASCII characters, character 0 in bits 7:0 |
| sys_reset_req | output | 1 | One-cycle system reset request |
| gp_out | output | 8 | General-purpose output |
| i2c_scl_out | output | 1 | I2C clock level toward the EEPROM |
| i2c_sda_out | output | 1 | I2C data level toward the EEPROM |
| i2c_oe | output | 2 | I2C output enables |
| i2c_sel | output | 1 | I2C port select |
| eeprom_sda_in | input | 1 | EEPROM data line level |

## Verification
Every result of this block is due exactly one clock edge after the access that causes it:
- register outputs and the display change at the write edge;
- `bus_rdata` is loaded at the edge where the address is presented;
- `sys_reset_req` is high only during the cycle after that edge.

The bench drives each access just after a falling edge. A behavioural model is updated just after each rising edge from the inputs held across it. Every output is compared with the model at the next falling edge, which is one full registered stage after the stimulus. Directed checks with fixed expected values sample at that same falling edge. The one-cycle width of the reset request and the "old value on read-during-write" rule follow directly from this timing.

// File: rtl/bcr_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the board control register file.
package bcr_pkg;
  localparam int OFF_W      = 20;  // decoded address bits
  localparam int DATA_W     = 32;
  localparam int CHAR_W     = 8;
  localparam int NCHARS     = 8;
  localparam int POS_STRIDE = 8;

  // Register offsets inside the decoded window.
  localparam logic [OFF_W-1:0] OFF_SWITCH   = 20'h00100;
  localparam logic [OFF_W-1:0] OFF_LED      = 20'h00400;
  localparam logic [OFF_W-1:0] OFF_WORD     = 20'h00410;
  localparam logic [OFF_W-1:0] OFF_POS_BASE = 20'h00418;
  localparam logic [OFF_W-1:0] OFF_SRST     = 20'h00500;
  localparam logic [OFF_W-1:0] OFF_UART_LO  = 20'h00900;
  localparam logic [OFF_W-1:0] OFF_UART_HI  = 20'h009FF;
  localparam logic [OFF_W-1:0] OFF_GPOUT    = 20'h00A00;
  localparam logic [OFF_W-1:0] OFF_I2C_IN   = 20'h00B00;
  localparam logic [OFF_W-1:0] OFF_I2C_OE   = 20'h00B04;
  localparam logic [OFF_W-1:0] OFF_I2C_OUT  = 20'h00B08;
  localparam logic [OFF_W-1:0] OFF_I2C_SEL  = 20'h00B0C;

  localparam logic [CHAR_W-1:0] CHAR_SPACE = 8'h20;

  // One flag per register; at most one is set for any offset.
  typedef struct packed {
    logic sw;
    logic led;
    logic word;
    logic pos;
    logic srst;
    logic gp;
    logic i2c_in;
    logic i2c_oe;
    logic i2c_out;
    logic i2c_sel;
  } bcr_hit_t;
endpackage

// File: rtl/bcr_decode.sv
`timescale 1ns/1ps
// Offset decoder: exact-match register flags, a strided character range,
// and exclusion of the neighbouring UART window.
module bcr_decode
  import bcr_pkg::*;
#(
  parameter int               W        = OFF_W,
  parameter int               N_CHARS  = NCHARS,
  parameter int               STRIDE   = POS_STRIDE,
  parameter logic [W-1:0]     A_SWITCH = OFF_SWITCH,
  parameter logic [W-1:0]     A_LED    = OFF_LED,
  parameter logic [W-1:0]     A_WORD   = OFF_WORD,
  parameter logic [W-1:0]     A_POS    = OFF_POS_BASE,
  parameter logic [W-1:0]     A_SRST   = OFF_SRST,
  parameter logic [W-1:0]     A_GP     = OFF_GPOUT,
  parameter logic [W-1:0]     A_I2CIN  = OFF_I2C_IN,
  parameter logic [W-1:0]     A_I2COE  = OFF_I2C_OE,
  parameter logic [W-1:0]     A_I2COUT = OFF_I2C_OUT,
  parameter logic [W-1:0]     A_I2CSEL = OFF_I2C_SEL,
  parameter logic [W-1:0]     A_HOLE_LO = OFF_UART_LO,
  parameter logic [W-1:0]     A_HOLE_HI = OFF_UART_HI,
  localparam int              IDX_W    = $clog2(N_CHARS),
  localparam int              SHIFT    = $clog2(STRIDE)
) (
  input  logic [W-1:0]     off,
  output bcr_hit_t         hit,
  output logic [IDX_W-1:0] pos_idx
);
  localparam int HI_W = W - SHIFT;
  localparam logic [HI_W-1:0] N_LIM = HI_W'(N_CHARS);

  logic          in_hole;
  logic [W-1:0]  rel;
  logic          pos_range;
  logic          pos_aligned;

  assign in_hole     = (off >= A_HOLE_LO) && (off <= A_HOLE_HI);
  assign rel         = off - A_POS;
  assign pos_range   = (off >= A_POS) && (rel[W-1:SHIFT] < N_LIM);
  assign pos_aligned = (rel[SHIFT-1:0] == '0);
  assign pos_idx     = rel[SHIFT +: IDX_W];

  always_comb begin
    hit = '0;
    if (!in_hole) begin
      hit.sw      = (off == A_SWITCH);
      hit.led     = (off == A_LED);
      hit.word    = (off == A_WORD);
      hit.pos     = pos_range && pos_aligned;
      hit.srst    = (off == A_SRST);
      hit.gp      = (off == A_GP);
      hit.i2c_in  = (off == A_I2CIN);
      hit.i2c_oe  = (off == A_I2COE);
      hit.i2c_out = (off == A_I2COUT);
      hit.i2c_sel = (off == A_I2CSEL);
    end
  end
endmodule

// File: rtl/bcr_hex_text.sv
`timescale 1ns/1ps
// Converts a data word into uppercase hexadecimal ASCII, one character
// per nibble; the most significant nibble lands in character 0.
module bcr_hex_text #(
  parameter  int DATA_W = 32,
  parameter  int CHAR_W = 8,
  localparam int N      = DATA_W / 4
) (
  input  logic [DATA_W-1:0]   value,
  output logic [N*CHAR_W-1:0] text
);
  for (genvar i = 0; i < N; i++) begin : g_nib
    logic [3:0] nib;
    assign nib = value[DATA_W-1-4*i -: 4];
    always_comb begin
      if (nib < 4'd10) text[i*CHAR_W +: CHAR_W] = CHAR_W'(8'h30) + CHAR_W'(nib);
      else             text[i*CHAR_W +: CHAR_W] = CHAR_W'(8'h37) + CHAR_W'(nib);
    end
  end
endmodule

// File: rtl/bcr_display.sv
`timescale 1ns/1ps
// Eight-character display buffer: bulk load from converted text or a
// single-character store at a decoded index.
module bcr_display #(
  parameter  int               N_CHARS = 8,
  parameter  int               CHAR_W  = 8,
  parameter  logic [CHAR_W-1:0] FILL   = 8'h20,
  localparam int               IDX_W   = $clog2(N_CHARS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_all,
  input  logic [N_CHARS*CHAR_W-1:0]   all_text,
  input  logic                        load_one,
  input  logic [IDX_W-1:0]            one_idx,
  input  logic [CHAR_W-1:0]           one_char,
  output logic [N_CHARS*CHAR_W-1:0]   chars
);
  for (genvar i = 0; i < N_CHARS; i++) begin : g_cell
    logic [CHAR_W-1:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   cell_q <= FILL;
      else if (load_all)                            cell_q <= all_text[i*CHAR_W +: CHAR_W];
      else if (load_one && (one_idx == IDX_W'(i)))  cell_q <= one_char;
    end
    assign chars[i*CHAR_W +: CHAR_W] = cell_q;
  end
endmodule

// File: rtl/bcr_misc_regs.sv
`timescale 1ns/1ps
// LED bar, general-purpose output, I2C bit-bang controls and the
// soft-reset pulse.
module bcr_misc_regs #(
  parameter int LED_W = 8,
  parameter int GP_W  = 8,
  parameter int OE_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_led,
  input  logic             wr_gp,
  input  logic             wr_oe,
  input  logic             wr_out,
  input  logic             wr_sel,
  input  logic             wr_srst,
  input  logic [7:0]       wbyte,
  output logic [LED_W-1:0] led,
  output logic [GP_W-1:0]  gp,
  output logic [OE_W-1:0]  oe,
  output logic             scl,
  output logic             sda,
  output logic             sel,
  output logic             srst_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led      <= '0;
      gp       <= '0;
      oe       <= '0;
      scl      <= 1'b0;
      sda      <= 1'b0;
      sel      <= 1'b0;
      srst_req <= 1'b0;
    end else begin
      if (wr_led) led <= wbyte[LED_W-1:0];
      if (wr_gp)  gp  <= wbyte[GP_W-1:0];
      if (wr_oe)  oe  <= wbyte[OE_W-1:0];
      if (wr_out) begin
        scl <= wbyte[1];
        sda <= wbyte[0];
      end
      if (wr_sel) sel <= wbyte[0];
      srst_req <= wr_srst;  // one cycle per write
    end
  end
endmodule

// File: rtl/board_ctrl_regs.sv
`timescale 1ns/1ps
// Board control register file top: decode, storage, read mux.
module board_ctrl_regs
  import bcr_pkg::*;
#(
  parameter  int ADDR_W = 32,
  localparam int TXT_W  = NCHARS * CHAR_W,
  localparam int IDX_W  = $clog2(NCHARS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [7:0]        led_bar,
  output logic [TXT_W-1:0]  disp_chars,
  output logic              sys_reset_req,
  output logic [7:0]        gp_out,
  output logic              i2c_scl_out,
  output logic              i2c_sda_out,
  output logic [1:0]        i2c_oe,
  output logic              i2c_sel,
  input  logic              eeprom_sda_in
);
  bcr_hit_t           hit;
  logic [IDX_W-1:0]   pos_idx;
  logic [TXT_W-1:0]   hex_text;
  logic [DATA_W-1:0]  rd_next;
  logic               unused_addr_hi;

  assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFF_W];

  bcr_decode #(.W(OFF_W), .N_CHARS(NCHARS), .STRIDE(POS_STRIDE)) u_dec (
    .off     (bus_addr[OFF_W-1:0]),
    .hit     (hit),
    .pos_idx (pos_idx)
  );

  bcr_hex_text #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_hex (
    .value (bus_wdata),
    .text  (hex_text)
  );

  bcr_display #(.N_CHARS(NCHARS), .CHAR_W(CHAR_W), .FILL(CHAR_SPACE)) u_disp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_all (bus_we && hit.word),
    .all_text (hex_text),
    .load_one (bus_we && hit.pos),
    .one_idx  (pos_idx),
    .one_char (bus_wdata[CHAR_W-1:0]),
    .chars    (disp_chars)
  );

  bcr_misc_regs #(.LED_W(8), .GP_W(8), .OE_W(2)) u_misc (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_led   (bus_we && hit.led),
    .wr_gp    (bus_we && hit.gp),
    .wr_oe    (bus_we && hit.i2c_oe),
    .wr_out   (bus_we && hit.i2c_out),
    .wr_sel   (bus_we && hit.i2c_sel),
    .wr_srst  (bus_we && hit.srst),
    .wbyte    (bus_wdata[7:0]),
    .led      (led_bar),
    .gp       (gp_out),
    .oe       (i2c_oe),
    .scl      (i2c_scl_out),
    .sda      (i2c_sda_out),
    .sel      (i2c_sel),
    .srst_req (sys_reset_req)
  );

  // Read mux; switch, write-only and unassigned offsets fall to zero.
  always_comb begin
    rd_next = '0;
    if (hit.led)     rd_next = DATA_W'(led_bar);
    if (hit.gp)      rd_next = DATA_W'(gp_out);
    if (hit.i2c_in)  rd_next = DATA_W'(eeprom_sda_in);
    if (hit.i2c_oe)  rd_next = DATA_W'(i2c_oe);
    if (hit.i2c_out) rd_next = DATA_W'({i2c_scl_out, i2c_sda_out});
    if (hit.i2c_sel) rd_next = DATA_W'(i2c_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end
endmodule

// File: rtl/board_ctrl_regs_chk.sv
`timescale 1ns/1ps
// Protocol checker bound to the register file top.
module board_ctrl_regs_chk
  import bcr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [OFF_W-1:0]  chk_off,
  input logic [7:0]        chk_wbyte,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [7:0]        led_bar,
  input logic [63:0]       disp_chars,
  input logic              sys_reset_req,
  input logic [7:0]        gp_out,
  input logic              eeprom_sda_in
);
  logic in_hole, disp_touch;
  assign in_hole    = (chk_off >= OFF_UART_LO) && (chk_off <= OFF_UART_HI);
  assign disp_touch = (chk_off == OFF_WORD) ||
                      ((chk_off >= OFF_POS_BASE) && (chk_off < OFF_POS_BASE + 20'd64));

  assert_led_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && chk_off == OFF_LED) |=> led_bar == $past(chk_wbyte));

  assert_led_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && chk_off == OFF_LED) |=> $stable(led_bar));

  assert_disp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && disp_touch) |=> $stable(disp_chars));

  assert_srst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> !sys_reset_req);

  assert_srst_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && chk_off == OFF_SRST) |=> sys_reset_req);

  assert_srst_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && chk_off == OFF_SRST) |=> !sys_reset_req);

  assert_switch_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_off == OFF_SWITCH) |=> bus_rdata == '0);

  assert_sda_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_off == OFF_I2C_IN) |=> bus_rdata == DATA_W'($past(eeprom_sda_in)));

  assert_hole_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_hole |=> (bus_rdata == '0) && $stable(led_bar) && $stable(gp_out)
                && $stable(disp_chars));
endmodule

bind board_ctrl_regs board_ctrl_regs_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .chk_off       (bus_addr[19:0]),
  .chk_wbyte     (bus_wdata[7:0]),
  .bus_we        (bus_we),
  .bus_rdata     (bus_rdata),
  .led_bar       (led_bar),
  .disp_chars    (disp_chars),
  .sys_reset_req (sys_reset_req),
  .gp_out        (gp_out),
  .eeprom_sda_in (eeprom_sda_in)
);

// File: tb/board_ctrl_regs_test.sv
`timescale 1ns/1ps
module board_ctrl_regs_test;
  import bcr_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        eeprom_sda_in = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  led_bar, gp_out;
  logic [63:0] disp_chars;
  logic        sys_reset_req, i2c_scl_out, i2c_sda_out, i2c_sel;
  logic [1:0]  i2c_oe;

  always #2.5 clk = ~clk;

  board_ctrl_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .led_bar(led_bar),
    .disp_chars(disp_chars), .sys_reset_req(sys_reset_req), .gp_out(gp_out),
    .i2c_scl_out(i2c_scl_out), .i2c_sda_out(i2c_sda_out), .i2c_oe(i2c_oe),
    .i2c_sel(i2c_sel), .eeprom_sda_in(eeprom_sda_in)
  );

  int tests = 0, fails = 0;
  bit done = 0, live = 0;

  // Behavioural reference state.
  logic [7:0]  m_led, m_gp, m_disp [8];
  logic [1:0]  m_oe;
  logic        m_scl, m_sda, m_sel, m_srst;
  logic [31:0] m_rd;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] m_text();
    logic [63:0] t;
    for (int i = 0; i < 8; i++) t[8*i +: 8] = m_disp[i];
    return t;
  endfunction

  function automatic logic [7:0] hexc(input int n);
    return (n < 10) ? 8'(48 + n) : 8'(65 + n - 10);
  endfunction

  function automatic logic [31:0] m_read(input logic [19:0] o);
    if (o >= 20'h900 && o <= 20'h9FF) return 0;
    if (o == OFF_LED)     return {24'b0, m_led};
    if (o == OFF_GPOUT)   return {24'b0, m_gp};
    if (o == OFF_I2C_IN)  return {31'b0, eeprom_sda_in};
    if (o == OFF_I2C_OE)  return {30'b0, m_oe};
    if (o == OFF_I2C_OUT) return {30'b0, m_scl, m_sda};
    if (o == OFF_I2C_SEL) return {31'b0, m_sel};
    return 0;
  endfunction

  // Model: advance just after each rising edge from the held inputs.
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      m_led = 0; m_gp = 0; m_oe = 0; m_scl = 0; m_sda = 0; m_sel = 0;
      m_srst = 0; m_rd = 0;
      for (int i = 0; i < 8; i++) m_disp[i] = 8'h20;
    end else begin
      logic [19:0] o;
      int rel;
      o = bus_addr[19:0];
      m_rd = m_read(o);
      m_srst = 0;
      if (bus_we && !(o >= 20'h900 && o <= 20'h9FF)) begin
        if (o == OFF_LED)     m_led = bus_wdata[7:0];
        if (o == OFF_GPOUT)   m_gp  = bus_wdata[7:0];
        if (o == OFF_I2C_OE)  m_oe  = bus_wdata[1:0];
        if (o == OFF_I2C_OUT) begin m_scl = bus_wdata[1]; m_sda = bus_wdata[0]; end
        if (o == OFF_I2C_SEL) m_sel = bus_wdata[0];
        if (o == OFF_SRST)    m_srst = 1;
        if (o == OFF_WORD)
          for (int i = 0; i < 8; i++) m_disp[i] = hexc(int'((bus_wdata >> (28 - 4*i)) & 32'hF));
        rel = int'(o) - int'(OFF_POS_BASE);
        if (rel >= 0 && rel < 64 && (rel % 8) == 0) m_disp[rel / 8] = bus_wdata[7:0];
      end
    end
  end

  // Compare every output with the model at each falling edge.
  always @(negedge clk) begin
    if (live) begin
      chk("R2",  "led_bar",   {56'b0, led_bar}, {56'b0, m_led});
      chk("R3",  "disp",      disp_chars, m_text());
      chk("R6",  "reset_req", {63'b0, sys_reset_req}, {63'b0, m_srst});
      chk("R7",  "i2c pins",  {59'b0, i2c_oe, i2c_scl_out, i2c_sda_out, i2c_sel},
                              {59'b0, m_oe, m_scl, m_sda, m_sel});
      chk("R11", "gp_out",    {56'b0, gp_out}, {56'b0, m_gp});
      chk("R10", "rdata",     {32'b0, bus_rdata}, {32'b0, m_rd});
    end
  end

  // Called at a falling edge; returns at the next one, where results show.
  task automatic cyc(input logic [31:0] a, input logic [31:0] d, input logic w);
    bus_addr = a; bus_wdata = d; bus_we = w;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL all watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1;
    // R5 reset state
    chk("R5", "disp reset", disp_chars, 64'h2020202020202020);
    chk("R5", "led reset",  {56'b0, led_bar}, 64'h0);
    // R2 LED keeps low byte; R10 read-back one cycle later
    cyc({12'b0, OFF_LED}, 32'h0000_01A5, 1);
    chk("R2", "led store", {56'b0, led_bar}, 64'hA5);
    cyc({12'b0, OFF_LED}, 32'h0, 0);
    chk("R10", "led read", {32'b0, bus_rdata}, 64'hA5);
    chk("R10", "read no effect", {56'b0, led_bar}, 64'hA5);
    // R11 general-purpose output
    cyc({12'b0, OFF_GPOUT}, 32'h0000_03C5, 1);
    chk("R11", "gp store", {56'b0, gp_out}, 64'hC5);
    cyc({12'b0, OFF_GPOUT}, 32'h0, 0);
    chk("R11", "gp read", {32'b0, bus_rdata}, 64'hC5);
    // R3 hex word conversion
    cyc({12'b0, OFF_WORD}, 32'h1234_ABCD, 1);
    chk("R3", "hex word 1", disp_chars, 64'h44434241_34333231);
    cyc({12'b0, OFF_WORD}, 32'hFEDC_0987, 1);
    chk("R3", "hex word 2", disp_chars, 64'h37383930_43444546);
    // R4 single characters and ignored offsets
    cyc(32'h0000_0430, 32'h0000_005A, 1);
    chk("R4", "char 3", disp_chars, 64'h37383930_5A444546);
    cyc(32'h0000_0450, 32'hFFFF_FF21, 1);
    chk("R4", "char 7", disp_chars, 64'h21383930_5A444546);
    cyc(32'h0000_041C, 32'h0000_0041, 1);
    chk("R4", "unaligned ignored", disp_chars, 64'h21383930_5A444546);
    cyc(32'h0000_0458, 32'h0000_0041, 1);
    chk("R4", "past end ignored", disp_chars, 64'h21383930_5A444546);
    // R1 upper address bits ignored
    cyc(32'hFFF0_0400, 32'h0000_003C, 1);
    chk("R1", "alias write", {56'b0, led_bar}, 64'h3C);
    cyc(32'hABC0_0400, 32'h0, 0);
    chk("R1", "alias read", {32'b0, bus_rdata}, 64'h3C);
    // R6 soft reset pulse
    cyc({12'b0, OFF_SRST}, 32'h0000_0042, 1);
    chk("R6", "pulse high", {63'b0, sys_reset_req}, 64'h1);
    cyc(32'h0, 32'h0, 0);
    chk("R6", "pulse ends", {63'b0, sys_reset_req}, 64'h0);
    // R7 I2C outputs
    cyc({12'b0, OFF_I2C_OUT}, 32'h0000_0002, 1);
    chk("R7", "scl=1 sda=0", {62'b0, i2c_scl_out, i2c_sda_out}, 64'h2);
    cyc({12'b0, OFF_I2C_OUT}, 32'h0000_0001, 1);
    chk("R7", "scl=0 sda=1", {62'b0, i2c_scl_out, i2c_sda_out}, 64'h1);
    cyc({12'b0, OFF_I2C_OE}, 32'h0000_00FF, 1);
    chk("R7", "oe 2 bits", {62'b0, i2c_oe}, 64'h3);
    cyc({12'b0, OFF_I2C_SEL}, 32'h0000_000F, 1);
    chk("R7", "sel 1 bit", {63'b0, i2c_sel}, 64'h1);
    cyc({12'b0, OFF_I2C_OUT}, 32'h0, 0);
    chk("R7", "out read", {32'b0, bus_rdata}, 64'h1);
    cyc({12'b0, OFF_I2C_OE}, 32'h0, 0);
    chk("R7", "oe read", {32'b0, bus_rdata}, 64'h3);
    // R8 EEPROM data input and switch register
    eeprom_sda_in = 1'b1;
    cyc({12'b0, OFF_I2C_IN}, 32'h0, 0);
    chk("R8", "sda in 1", {32'b0, bus_rdata}, 64'h1);
    eeprom_sda_in = 1'b0;
    cyc({12'b0, OFF_I2C_IN}, 32'h0, 0);
    chk("R8", "sda in 0", {32'b0, bus_rdata}, 64'h0);
    cyc({12'b0, OFF_SWITCH}, 32'hFFFF_FFFF, 1);
    chk("R8", "switch zero", {32'b0, bus_rdata}, 64'h0);
    // R9 UART window and unknown offsets
    cyc(32'h0000_0908, 32'hFFFF_FFFF, 1);
    chk("R9", "hole led", {56'b0, led_bar}, 64'h3C);
    chk("R9", "hole gp",  {56'b0, gp_out}, 64'hC5);
    chk("R9", "hole disp", disp_chars, 64'h21383930_5A444546);
    cyc(32'h0000_0900, 32'h0, 0);
    chk("R9", "hole read", {32'b0, bus_rdata}, 64'h0);
    cyc(32'h0007_FFF0, 32'h0, 0);
    chk("R9", "unknown read", {32'b0, bus_rdata}, 64'h0);
    // R5 reset in mid-run
    rst_n = 1'b0;
    live = 0;
    @(negedge clk);
    chk("R5", "re-reset disp", disp_chars, 64'h2020202020202020);
    chk("R5", "re-reset regs", {46'b0, led_bar, gp_out, i2c_oe}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    live = 1;
    cyc(32'h0, 32'h0, 0);
    finish_run();
  end
endmodule